// File: doc/BRIEF.md
# Time-Slotted Wavefront Register File

This block is the vector register storage that one SIMD uses to serve a 64-thread wavefront. Each register is 128 bits wide and holds four 32-bit components X, Y, Z and W. Sixteen lanes handle sixteen threads per clock, so a full wavefront is covered by four lane quads. Access is not arbitrated on demand. A free-running four-phase slot schedule gives each clock one read class and one write class. Over one pass of the four slots, all traffic works on the same lane quad. The quad then advances, so one source operand for all 64 threads takes 16 clocks.

Each traffic class has its own request, index and acknowledge port. The write classes also carry a component mask and a 16-lane data word. A client holds its request until the slot for its class comes up. It is acknowledged in that cycle. The read result appears one clock later on a shared return bus, tagged with its class and quad. A thread-relative index first selects either the clause-temporary region, which all waves share, or the current wave's region, which is placed by a wave base. An access outside the wave's allocation is dropped and raises a sticky error.

Top module: `wave_vrf`

## Requirements
- R1: After reset `slot` is 0 and `quad` is 0. `slot` advances by one every clock modulo 4. `quad` advances by one, modulo 4 (the number of quads), on each clock in which `slot` is 3, and is otherwise held.
- R2: An operand-A read request is acknowledged only when `slot` is 0, and an operand-B read only when `slot` is 1. A vector-result write is acknowledged only in slot 0, and a scalar-result write only in slot 1. A request with no matching slot waits.
- R3: In slot 2, an operand-C read is granted ahead of an export read. The export read is granted in slot 2 only when no operand-C request is present. An interpolator write is acknowledged in slot 2.
- R4: In slot 3, a texture-address read is granted ahead of an export read. The export read is granted in slot 3 only when no texture-address request is present. A texture-data write is acknowledged in slot 3.
- R5: One clock after a read grant, `rd_valid` is 1. `rd_tag` gives the class (0 operand A, 1 operand B, 2 operand C, 3 export, 4 texture address). `rd_quad` is the quad of the grant cycle. In every other cycle `rd_valid` is 0.
- R6: A write updates only the components whose mask bit is set. Lane l occupies data bits [l*128+127 : l*128]. Component c (X=0, Y=1, Z=2, W=3) of a lane occupies bits [c*32+31 : c*32] within that lane, and mask bit c controls it. Unmasked components keep their old value.
- R7: An index below TEMPS selects physical register `index`, whatever the wave base. An index i of TEMPS or more selects physical register TEMPS + `wave_base` + (i - TEMPS). A read returns the 16-lane contents of the selected register for the current quad.
- R8: An access is dropped when i - TEMPS is not below `wave_cnt`, or when the physical register is DEPTH or more. A dropped write changes nothing. A dropped read returns all-zero data. Either case sets `err`, which stays 1 until reset.
- R9: A read granted in the same cycle as a write to the same register and quad returns the value from before the write.
- R10: Reset clears `rd_valid` and `err`. Register contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_base | input | IW | Physical offset of the current wave's region |
| wave_cnt | input | IW | Number of per-wave registers allocated |
| slot | output | 2 | Current slot of the schedule |
| quad | output | 2 | Current lane quad |
| opa_req | input | 1 | Operand-A read request |
| opa_idx | input | IW | Operand-A register index |
| opa_ack | output | 1 | Operand-A grant |
| opb_req | input | 1 | Operand-B read request |
| opb_idx | input | IW | Operand-B register index |
| opb_ack | output | 1 | Operand-B grant |
| opc_req | input | 1 | Operand-C read request |
| opc_idx | input | IW | Operand-C register index |
| opc_ack | output | 1 | Operand-C grant |
| xpt_req | input | 1 | Export read request |
| xpt_idx | input | IW | Export register index |
| xpt_ack | output | 1 | Export grant |
| txa_req | input | 1 | Texture-address read request |
| txa_idx | input | IW | Texture-address register index |
| txa_ack | output | 1 | Texture-address grant |
| vres_req | input | 1 | Vector-result write request |
| vres_idx | input | IW | Vector-result register index |
| vres_mask | input | 4 | Vector-result component mask |
| vres_data | input | LANES*128 | Vector-result data |
| vres_ack | output | 1 | Vector-result grant |
| sres_req | input | 1 | Scalar-result write request |
| sres_idx | input | IW | Scalar-result register index |
| sres_mask | input | 4 | Scalar-result component mask |
| sres_data | input | LANES*128 | Scalar-result data |
| sres_ack | output | 1 | Scalar-result grant |
| intp_req | input | 1 | Interpolator write request |
| intp_idx | input | IW | Interpolator register index |
| intp_mask | input | 4 | Interpolator component mask |
| intp_data | input | LANES*128 | Interpolator data |
| intp_ack | output | 1 | Interpolator grant |
| txd_req | input | 1 | Texture-data write request |
| txd_idx | input | IW | Texture-data register index |
| txd_mask | input | 4 | Texture-data component mask |
| txd_data | input | LANES*128 | Texture-data write data |
| txd_ack | output | 1 | Texture-data grant |
| rd_valid | output | 1 | Read return valid |
| rd_tag | output | 3 | Class of the returned read |
| rd_quad | output | 2 | Quad of the returned read |
| rd_data | output | LANES*128 | Returned 16-lane register contents |
| err | output | 1 | Sticky out-of-range flag |

## Verification
`slot` and `quad` follow only from the number of clocks since reset, so their expected values are known on every clock. Grants are combinational in the slot cycle. The bench compares them shortly after it drives the requests on the falling edge. Read data, tag, quad and the error flag change at the rising edge after a grant, and they are compared on the falling edge that follows. A write is visible only to reads granted in later cycles, which also gives the read-before-write case its expected value.

// File: rtl/wave_vrf.sv
module wave_vrf #(
  parameter int LANES   = 16,
  parameter int THREADS = 64,
  parameter int DEPTH   = 16,
  parameter int TEMPS   = 4,
  parameter int IW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         wave_base,
  input  logic [IW-1:0]         wave_cnt,
  output logic [1:0]            slot,
  output logic [$clog2(THREADS/LANES)-1:0] quad,
  input  logic                  opa_req,
  input  logic [IW-1:0]         opa_idx,
  output logic                  opa_ack,
  input  logic                  opb_req,
  input  logic [IW-1:0]         opb_idx,
  output logic                  opb_ack,
  input  logic                  opc_req,
  input  logic [IW-1:0]         opc_idx,
  output logic                  opc_ack,
  input  logic                  xpt_req,
  input  logic [IW-1:0]         xpt_idx,
  output logic                  xpt_ack,
  input  logic                  txa_req,
  input  logic [IW-1:0]         txa_idx,
  output logic                  txa_ack,
  input  logic                  vres_req,
  input  logic [IW-1:0]         vres_idx,
  input  logic [3:0]            vres_mask,
  input  logic [LANES*128-1:0]  vres_data,
  output logic                  vres_ack,
  input  logic                  sres_req,
  input  logic [IW-1:0]         sres_idx,
  input  logic [3:0]            sres_mask,
  input  logic [LANES*128-1:0]  sres_data,
  output logic                  sres_ack,
  input  logic                  intp_req,
  input  logic [IW-1:0]         intp_idx,
  input  logic [3:0]            intp_mask,
  input  logic [LANES*128-1:0]  intp_data,
  output logic                  intp_ack,
  input  logic                  txd_req,
  input  logic [IW-1:0]         txd_idx,
  input  logic [3:0]            txd_mask,
  input  logic [LANES*128-1:0]  txd_data,
  output logic                  txd_ack,
  output logic                  rd_valid,
  output logic [2:0]            rd_tag,
  output logic [$clog2(THREADS/LANES)-1:0] rd_quad,
  output logic [LANES*128-1:0]  rd_data,
  output logic                  err
);
  localparam int DW    = LANES * 128;
  localparam int QUADS = THREADS / LANES;
  localparam int QW    = $clog2(QUADS);
  localparam int PW    = $clog2(DEPTH);
  localparam int EW    = IW + 2;

  logic [DW-1:0] mem [DEPTH][QUADS];

  function automatic logic [EW:0] map_idx(input logic [IW-1:0] idx,
                                          input logic [IW-1:0] base,
                                          input logic [IW-1:0] cnt);
    logic [EW-1:0] e, off, p;
    logic ok;
    e   = EW'(idx);
    off = e - EW'(TEMPS);
    if (e < EW'(TEMPS)) begin
      p  = e;
      ok = 1'b1;
    end else begin
      p  = EW'(TEMPS) + EW'(base) + off;
      ok = off < EW'(cnt);
    end
    ok = ok && (p < EW'(DEPTH));
    return {ok, p};
  endfunction

  assign opa_ack  = opa_req  && slot == 2'd0;
  assign opb_ack  = opb_req  && slot == 2'd1;
  assign opc_ack  = opc_req  && slot == 2'd2;
  assign txa_ack  = txa_req  && slot == 2'd3;
  assign xpt_ack  = xpt_req  && ((slot == 2'd2 && !opc_req) || (slot == 2'd3 && !txa_req));
  assign vres_ack = vres_req && slot == 2'd0;
  assign sres_ack = sres_req && slot == 2'd1;
  assign intp_ack = intp_req && slot == 2'd2;
  assign txd_ack  = txd_req  && slot == 2'd3;

  logic          r_go, w_go;
  logic [IW-1:0] r_idx, w_idx;
  logic [2:0]    r_tag;
  logic [3:0]    w_mask;
  logic [DW-1:0] w_data, wbm;

  assign r_go = opa_ack | opb_ack | opc_ack | xpt_ack | txa_ack;
  assign w_go = vres_ack | sres_ack | intp_ack | txd_ack;

  always_comb begin
    r_idx = '0;
    r_tag = 3'd0;
    if (opa_ack)      begin r_idx = opa_idx; r_tag = 3'd0; end
    else if (opb_ack) begin r_idx = opb_idx; r_tag = 3'd1; end
    else if (opc_ack) begin r_idx = opc_idx; r_tag = 3'd2; end
    else if (xpt_ack) begin r_idx = xpt_idx; r_tag = 3'd3; end
    else if (txa_ack) begin r_idx = txa_idx; r_tag = 3'd4; end
  end

  always_comb begin
    w_idx  = '0;
    w_mask = '0;
    w_data = '0;
    unique case (slot)
      2'd0: begin w_idx = vres_idx; w_mask = vres_mask; w_data = vres_data; end
      2'd1: begin w_idx = sres_idx; w_mask = sres_mask; w_data = sres_data; end
      2'd2: begin w_idx = intp_idx; w_mask = intp_mask; w_data = intp_data; end
      default: begin w_idx = txd_idx; w_mask = txd_mask; w_data = txd_data; end
    endcase
  end

  assign wbm = {LANES{{{32{w_mask[3]}}, {32{w_mask[2]}}, {32{w_mask[1]}}, {32{w_mask[0]}}}}};

  logic [EW:0]   rm, wm;
  logic          r_ok, w_ok;
  logic [PW-1:0] r_p, w_p;
  logic          unused_hi;

  assign rm   = map_idx(r_idx, wave_base, wave_cnt);
  assign wm   = map_idx(w_idx, wave_base, wave_cnt);
  assign r_ok = rm[EW];
  assign w_ok = wm[EW];
  assign r_p  = rm[PW-1:0];
  assign w_p  = wm[PW-1:0];
  assign unused_hi = ^{rm[EW-1:PW], wm[EW-1:PW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= 2'd0;
      quad     <= '0;
      rd_valid <= 1'b0;
      rd_tag   <= 3'd0;
      rd_quad  <= '0;
      err      <= 1'b0;
    end else begin
      slot     <= slot + 2'd1;
      if (slot == 2'd3)
        quad <= (quad == QW'(QUADS - 1)) ? '0 : quad + 1'b1;
      rd_valid <= r_go;
      if (r_go) begin
        rd_tag  <= r_tag;
        rd_quad <= quad;
      end
      if ((r_go && !r_ok) || (w_go && !w_ok))
        err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (w_go && w_ok)
      mem[w_p][quad] <= (mem[w_p][quad] & ~wbm) | (w_data & wbm);
    if (r_go)
      rd_data <= r_ok ? mem[r_p][quad] : '0;
  end

  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> slot == $past(slot) + 2'd1);

  a_r1_quad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slot != 2'd3 |=> $stable(quad));

  a_r3_xpt_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (xpt_ack && slot == 2'd2) |-> !opc_req);

  a_r4_xpt_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (xpt_ack && slot == 2'd3) |-> !txa_req);

  a_r5_ret_valid: assert property (@(posedge clk) disable iff (!rst_n)
    r_go |=> rd_valid);

  a_r5_ret_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !r_go |=> !rd_valid);

  a_r5_ret_quad: assert property (@(posedge clk) disable iff (!rst_n)
    r_go |=> rd_quad == $past(quad));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((r_go && !r_ok) || (w_go && !w_ok)) |=> err);
endmodule

// File: tb/wave_vrf_tb_top.sv
module wave_vrf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16, THREADS = 64, DEPTH = 16, TEMPS = 4, IW = 8;
  localparam int DW = LANES * 128;
  localparam int QUADS = THREADS / LANES;
  localparam int QW = $clog2(QUADS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          pend  [9];
  logic [IW-1:0] idx_b [9];
  logic [3:0]    mask_b[4];
  logic [DW-1:0] data_b[4];
  int base_i, cnt_i;

  logic [1:0] slot;
  logic [QW-1:0] quad, rd_quad;
  logic opa_ack, opb_ack, opc_ack, xpt_ack, txa_ack, vres_ack, sres_ack, intp_ack, txd_ack;
  logic rd_valid, err;
  logic [2:0] rd_tag;
  logic [DW-1:0] rd_data;

  wave_vrf #(.LANES(LANES), .THREADS(THREADS), .DEPTH(DEPTH), .TEMPS(TEMPS), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wave_base(IW'(base_i)), .wave_cnt(IW'(cnt_i)),
    .slot(slot), .quad(quad),
    .opa_req(pend[0]), .opa_idx(idx_b[0]), .opa_ack(opa_ack),
    .opb_req(pend[1]), .opb_idx(idx_b[1]), .opb_ack(opb_ack),
    .opc_req(pend[2]), .opc_idx(idx_b[2]), .opc_ack(opc_ack),
    .xpt_req(pend[3]), .xpt_idx(idx_b[3]), .xpt_ack(xpt_ack),
    .txa_req(pend[4]), .txa_idx(idx_b[4]), .txa_ack(txa_ack),
    .vres_req(pend[5]), .vres_idx(idx_b[5]), .vres_mask(mask_b[0]), .vres_data(data_b[0]), .vres_ack(vres_ack),
    .sres_req(pend[6]), .sres_idx(idx_b[6]), .sres_mask(mask_b[1]), .sres_data(data_b[1]), .sres_ack(sres_ack),
    .intp_req(pend[7]), .intp_idx(idx_b[7]), .intp_mask(mask_b[2]), .intp_data(data_b[2]), .intp_ack(intp_ack),
    .txd_req(pend[8]), .txd_idx(idx_b[8]), .txd_mask(mask_b[3]), .txd_data(data_b[3]), .txd_ack(txd_ack),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_quad(rd_quad), .rd_data(rd_data), .err(err)
  );

  int ntot = 0, nbad = 0, bcyc = 0;
  bit done = 0;
  string lbl = "R7";
  string ctag[9] = '{"R2", "R2", "R3", "R3", "R4", "R2", "R2", "R3", "R4"};
  logic [DW-1:0] mdl [DEPTH][QUADS];
  logic e_rv = 0, e_err = 0;
  int e_tag = 0, e_rq = 0;
  logic [DW-1:0] e_rd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int mapp(int idx);
    int p;
    if (idx < TEMPS) p = idx;
    else begin
      if (idx - TEMPS >= cnt_i) return -1;
      p = TEMPS + base_i + idx - TEMPS;
    end
    if (p >= DEPTH) return -1;
    return p;
  endfunction

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] r;
    for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic cycle();
    int s, q, p;
    logic [8:0] ea, aa;
    s = bcyc % 4;
    q = (bcyc / 4) % QUADS;
    #1;
    chk(slot == 2'(s), "R1", "slot", DW'(slot), DW'(s));
    chk(quad == QW'(q), "R1", "quad", DW'(quad), DW'(q));
    chk(rd_valid == e_rv, "R5", "rd_valid", DW'(rd_valid), DW'(e_rv));
    if (e_rv) begin
      chk(rd_tag == 3'(e_tag), "R5", "rd_tag", DW'(rd_tag), DW'(e_tag));
      chk(rd_quad == QW'(e_rq), "R5", "rd_quad", DW'(rd_quad), DW'(e_rq));
      chk(rd_data == e_rd, lbl, "rd_data", rd_data, e_rd);
    end
    chk(err == e_err, "R8", "err", DW'(err), DW'(e_err));
    ea[0] = pend[0] && s == 0;
    ea[1] = pend[1] && s == 1;
    ea[2] = pend[2] && s == 2;
    ea[3] = pend[3] && ((s == 2 && !pend[2]) || (s == 3 && !pend[4]));
    ea[4] = pend[4] && s == 3;
    for (int w = 0; w < 4; w++) ea[5+w] = pend[5+w] && s == w;
    aa = {txd_ack, intp_ack, sres_ack, vres_ack, txa_ack, xpt_ack, opc_ack, opb_ack, opa_ack};
    for (int k = 0; k < 9; k++)
      chk(aa[k] == ea[k], ctag[k], $sformatf("ack%0d", k), DW'(aa[k]), DW'(ea[k]));
    e_rv = 0;
    for (int k = 0; k < 5; k++) if (ea[k]) begin
      e_rv = 1; e_tag = k; e_rq = q;
      p = mapp(int'(idx_b[k]));
      if (p < 0) begin e_rd = '0; e_err = 1; end
      else e_rd = mdl[p][q];
    end
    if (ea[5+s]) begin
      p = mapp(int'(idx_b[5+s]));
      if (p < 0) e_err = 1;
      else begin
        logic [DW-1:0] m;
        for (int l = 0; l < LANES; l++)
          for (int c = 0; c < 4; c++)
            m[l*128 + c*32 +: 32] = {32{mask_b[s][c]}};
        mdl[p][q] = (mdl[p][q] & ~m) | (data_b[s] & m);
      end
    end
    @(posedge clk);
    bcyc++;
    @(negedge clk);
    for (int k = 0; k < 9; k++) if (ea[k]) pend[k] = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 9; k++) while (pend[k]) cycle();
  endtask

  task automatic align(int s);
    while (bcyc % 4 != s) cycle();
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 9; k++) if (!pend[k] && ($urandom % 2 == 1)) begin
        pend[k] = 1;
        idx_b[k] = IW'($urandom % 16);
        if (k >= 5) begin
          mask_b[k-5] = 4'($urandom % 16);
          data_b[k-5] = rnd_data();
        end
      end
      cycle();
    end
  endtask

  task automatic wr_req(int k, int idx, logic [3:0] m);
    pend[k] = 1; idx_b[k] = IW'(idx); mask_b[k-5] = m; data_b[k-5] = rnd_data();
  endtask

  task automatic rd_req(int k, int idx);
    pend[k] = 1; idx_b[k] = IW'(idx);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin pend[k] = 0; idx_b[k] = '0; end
    for (int w = 0; w < 4; w++) begin mask_b[w] = '0; data_b[w] = '0; end
    base_i = 0; cnt_i = DEPTH - TEMPS;
    repeat (3) @(negedge clk);
    #1;
    chk(slot == 2'd0, "R1", "reset slot", DW'(slot), '0);
    chk(quad == '0, "R1", "reset quad", DW'(quad), '0);
    chk(rd_valid == 1'b0, "R10", "reset rd_valid", DW'(rd_valid), '0);
    chk(err == 1'b0, "R10", "reset err", DW'(err), '0);
    @(negedge clk);
    rst_n = 1'b1;

    lbl = "R7";
    for (int i = 0; i < DEPTH * QUADS * 4; i++) begin
      if (bcyc % 4 == 0) wr_req(5, bcyc / (4 * QUADS), 4'hf);
      cycle();
    end
    rand_run(600);

    drain(); align(0);
    lbl = "R9";
    rd_req(0, 1); wr_req(5, 1, 4'hf);
    cycle(); cycle();
    rd_req(0, 6); wr_req(5, 6, 4'h5);
    repeat (4) cycle();

    drain(); align(0);
    lbl = "R6";
    wr_req(5, 2, 4'b0101); rd_req(2, 2);
    repeat (4) cycle();
    wr_req(6, 3, 4'b1000); rd_req(4, 3);
    repeat (4) cycle();
    rand_run(300);

    drain(); align(2);
    lbl = "R7";
    rd_req(2, 0); rd_req(3, 1); rd_req(4, 2);
    repeat (6) cycle();
    drain(); align(3);
    rd_req(4, 5); rd_req(3, 7);
    repeat (4) cycle();

    drain();
    base_i = 3; cnt_i = 5;
    rand_run(600);
    drain();
    lbl = "R8";
    base_i = 8; cnt_i = 8;
    rand_run(600);
    drain();
    rd_req(0, 15); wr_req(6, 15, 4'hf);
    repeat (6) cycle();

    drain();
    rst_n = 1'b0;
    e_rv = 0; e_err = 0; bcyc = 0;
    @(negedge clk);
    #1;
    chk(err == 1'b0, "R10", "err after reset", DW'(err), '0);
    chk(rd_valid == 1'b0, "R10", "rd_valid after reset", DW'(rd_valid), '0);
    chk(slot == 2'd0, "R1", "slot after reset", DW'(slot), '0);
    @(negedge clk);
    rst_n = 1'b1;
    lbl = "R10";
    base_i = 0; cnt_i = DEPTH - TEMPS;
    rand_run(200);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule